// File: doc/BRIEF.md
# Match-Compare Event Timer

A memory-mapped up-counter with a compare register, a programmable tick prescaler and a one-shot event output. Software programs a compare value and starts the counter, and the block reports each time the count reaches that value. An optional auto-restart mode returns the count to zero on every hit, which turns the timer into a periodic event source. The count keeps running past the compare value and wraps, so the count register can also serve as a free-running time base.

The register port is a single-cycle write strobe with address and data. Read data is combinational from the address. The counter steps once per prescaler tick. A two-bit code `N` stretches the tick period to `N+1` clock cycles.

Top module: `evt_timer`

## Requirements
- R1: After reset the count reads 0, the compare value reads all ones (CNT_W bits), the control and prescaler registers read 0, and `irq_o` is low.
- R2: The compare register at offset 0x00 is read/write (CNT_W bits, zero-extended on read). The count at 0x04 is read-only and ignores writes. Control at 0x08 holds bit 0 = run and bit 1 = auto-restart. The prescaler code at 0x34 holds bits [1:0]. All other bits of these registers read 0.
- R3: While run is 1, the count rises by one per prescaler tick. After run is written to 0, the count holds its value.
- R4: Any write to offset 0x0C, whatever the data, sets the count to 0 at that clock edge. Offset 0x0C reads as 0.
- R5: Prescaler code N (0..3) produces one tick every N+1 cycles. The first step comes N+1 cycles after the run bit is set or after the code is rewritten, because a write to 0x34 restarts the prescaler phase.
- R6: `irq_o` is a one-cycle pulse. It is asserted in the cycle after the count first equals the compare value while running, and it is not repeated while that equality persists.
- R7: With auto-restart set, a tick that finds the count equal to the compare value loads 0 instead of incrementing.
- R8: The count wraps from all ones to 0 and keeps counting.
- R9: A compare value written below the current count raises no event until the count wraps around and reaches it.
- R10: Writes to unmapped offsets change no register, and reads from unmapped offsets return 0.
- R11: While run is 0, a count equal to the compare value raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq_o | output | 1 | One-cycle compare event pulse |

## Verification
The bench runs an 8-bit counter so that wrap-around can be reached. It sweeps all four prescaler codes, tracking the cycle at which each step must appear. A prescaler that does not restart its phase, or that is off by one, shifts every step and fails the count comparison in that cycle. A compare value held for four cycles catches an event output that is level-sensitive instead of edge-detected. An auto-restart run catches a counter that passes the compare value or restarts one cycle early. A compare value written behind the count catches a greater-or-equal comparison, which would fire at once instead of after the wrap. Writes to the count, to unused bits and to unmapped offsets catch address decode that aliases or leaks.

// File: rtl/evt_timer_pkg.sv
// Package evt_timer_pkg
// Shared register offsets and field widths for the match-compare timer.
// Assumes byte offsets fit in 8 bits; the top widens them to its address bus.
package evt_timer_pkg;
    localparam int          DIV_CODE_W = 2;
    localparam logic [7:0]  OFS_MATCH  = 8'h00;
    localparam logic [7:0]  OFS_COUNT  = 8'h04;
    localparam logic [7:0]  OFS_CTRL   = 8'h08;
    localparam logic [7:0]  OFS_CLEAR  = 8'h0C;
    localparam logic [7:0]  OFS_DIV    = 8'h34;

    typedef logic [DIV_CODE_W-1:0] div_code_t;

    typedef struct packed {
        logic restart;   // bit 1: zero the count on a compare hit
        logic run;       // bit 0: count enable
    } ctrl_t;
endpackage

// File: rtl/evt_tick_div.sv
// Module evt_tick_div
// Prescaler that emits a one-cycle tick every code_i+1 cycles while run_i is 1.
// Assumes code_i changes only together with reload_i. The phase is held at 0
// while stopped and is restarted by reload_i, so the first tick always comes
// one full period after either event.
module evt_tick_div
    import evt_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      reload_i,
    input  div_code_t code_i,
    output logic      tick_o
);
    div_code_t phase_q;

    // Phase counter: hold at zero when stopped or reloaded, else cycle 0..code_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i || reload_i) begin
            phase_q <= '0;
        end else if (phase_q == code_i) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && (phase_q == code_i);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && code_i != '0 && !reload_i) |=> !tick_o); // R5
endmodule

// File: rtl/evt_match_cnt.sv
// Module evt_match_cnt
// Counter with compare and event pulse. It steps on tick_i, zeroes on clr_i,
// optionally restarts on a compare hit, and pulses irq_o once per new hit.
// Assumes tick_i is only high while run_i is high.
module evt_match_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] match_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] count_q;
    logic             hit;
    logic             hit_q;
    logic             irq_q;

    assign hit = run_i && (count_q == match_i);

    // Count register: clear has priority, then restart-on-hit, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (tick_i) begin
            if (restart_i && count_q == match_i) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // Event edge detector: pulse once when the hit condition first appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            hit_q <= hit;
            irq_q <= hit && !hit_q;
        end
    end

    assign count_o = count_q;
    assign irq_o   = irq_q;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(run_i && count_q == match_i)); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(count_q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_q == '0); // R4
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && restart_i && count_q == match_i) |=> count_q == '0); // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_q == '1) |=> count_q == '0); // R8
endmodule

// File: rtl/evt_timer.sv
// Module evt_timer
// Top of the match-compare timer: register decode and readback, plus the
// prescaler and counter instances. Writes take effect at the strobe's clock
// edge, and read data follows bus_addr combinationally. Assumes
// CNT_W <= DATA_W and ADDR_W >= 6.
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFS_DIV);

    logic [CNT_W-1:0] match_q;
    ctrl_t            ctrl_q;
    div_code_t        div_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             wr_match, wr_ctrl, wr_clear, wr_div, wr_mapped;

    // Write decode, one strobe per mapped offset.
    assign wr_match  = bus_wr && (bus_addr == A_MATCH);
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_clear  = bus_wr && (bus_addr == A_CLEAR);
    assign wr_div    = bus_wr && (bus_addr == A_DIV);
    assign wr_mapped = wr_match || wr_ctrl || wr_clear || wr_div
                       || (bus_wr && bus_addr == A_COUNT);

    // Configuration registers: compare value, control bits, prescaler code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '1;
            ctrl_q  <= '0;
            div_q   <= '0;
        end else begin
            if (wr_match) match_q <= bus_wdata[CNT_W-1:0];
            if (wr_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[1:0]);
            if (wr_div)   div_q   <= bus_wdata[DIV_CODE_W-1:0];
        end
    end

    // Read mux: mapped registers zero-extended, everything else reads 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MATCH: bus_rdata = DATA_W'(match_q);
            A_COUNT: bus_rdata = DATA_W'(count);
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_DIV:   bus_rdata = DATA_W'(div_q);
            default: bus_rdata = '0;
        endcase
    end

    evt_tick_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl_q.run),
        .reload_i (wr_div),
        .code_i   (div_q),
        .tick_o   (tick)
    );

    evt_match_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_i     (ctrl_q.run),
        .restart_i (ctrl_q.restart),
        .clr_i     (wr_clear),
        .match_i   (match_q),
        .count_o   (count),
        .irq_o     (irq_o)
    );

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_mapped) |=> ($stable(match_q) && $stable(ctrl_q) && $stable(div_q))); // R10
    AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !$past(ctrl_q.run)) |-> !irq_o); // R11
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/100ps
module tb_evt_timer;
    localparam int W = 8;
    localparam logic [7:0] RA_MATCH = 8'h00, RA_COUNT = 8'h04, RA_CTRL = 8'h08,
                           RA_CLEAR = 8'h0C, RA_DIV = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    int ecnt   = 0;
    bit done   = 1'b0;

    evt_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", req, act, exp, ecnt);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ecnt++;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic setup(input logic [31:0] match, input logic [31:0] code);
        wr(RA_CTRL, 0);
        wr(RA_CLEAR, 0);
        wr(RA_MATCH, match);
        wr(RA_DIV, code);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        int base, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(RA_COUNT, v); chk("R1 count", v, 0);
        rd(RA_MATCH, v); chk("R1 match", v, 32'hFF);
        rd(RA_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(RA_DIV, v);   chk("R1 div", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        repeat (4) step();
        rd(RA_COUNT, v); chk("R1 count idle", v, 0);

        // R2 field widths and read-only count
        wr(RA_MATCH, 32'hFFFF_FF5A); rd(RA_MATCH, v); chk("R2 match width", v, 32'h5A);
        wr(RA_CTRL, 32'hFFFF_FFFC);  rd(RA_CTRL, v);  chk("R2 ctrl bits", v, 0);
        wr(RA_DIV, 32'h0000_0007);   rd(RA_DIV, v);   chk("R2 div bits", v, 3);
        wr(RA_DIV, 0);
        wr(RA_COUNT, 32'h33);        rd(RA_COUNT, v); chk("R2 count read-only", v, 0);
        rd(RA_CLEAR, v);             chk("R4 clear reads zero", v, 0);

        // R10 unmapped writes and reads
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        rd(RA_MATCH, v); chk("R10 match kept", v, 32'h5A);
        rd(RA_CTRL, v);  chk("R10 ctrl kept", v, 0);
        rd(RA_DIV, v);   chk("R10 div kept", v, 0);
        rd(RA_COUNT, v); chk("R10 count kept", v, 0);
        rd(8'h10, v);    chk("R10 read 0x10", v, 0);
        rd(8'hFC, v);    chk("R10 read 0xFC", v, 0);

        // R5 sweep of every prescaler code from a stopped timer
        for (int n = 0; n < 4; n++) begin
            setup(32'hFF, n);
            wr(RA_CTRL, 1);
            base = ecnt;
            for (int i = 0; i < 13; i++) begin
                e = ecnt - base;
                rd(RA_COUNT, v); chk("R5 divided count", v, e / (n + 1));
                chk("R5 no event", {31'd0, irq_o}, 0);
                step();
            end
        end

        // R5 rewriting the code while running restarts the phase
        setup(32'hFF, 0);
        wr(RA_CTRL, 1);
        repeat (3) step();
        wr(RA_DIV, 2);
        base = ecnt;
        rd(RA_COUNT, c0); chk("R5 count at code write", c0, 4);
        for (int i = 0; i < 10; i++) begin
            e = ecnt - base;
            rd(RA_COUNT, v); chk("R5 phase restart", v, c0 + e / 3);
            step();
        end

        // R3 stopping holds the count
        wr(RA_DIV, 0);
        wr(RA_CTRL, 0);
        rd(RA_COUNT, c0);
        for (int i = 0; i < 6; i++) begin
            step();
            rd(RA_COUNT, v); chk("R3 hold when stopped", v, c0);
        end
        wr(RA_CTRL, 1);
        rd(RA_COUNT, v); chk("R3 resumes", v, c0);
        step();
        rd(RA_COUNT, v); chk("R3 steps after resume", v, c0 + 1);

        // R4 clear with arbitrary data while running
        repeat (3) step();
        wr(RA_CLEAR, 32'hA5);
        rd(RA_COUNT, v); chk("R4 cleared", v, 0);
        step();
        rd(RA_COUNT, v); chk("R4 counts from zero", v, 1);

        // R6 compare held for four cycles gives one pulse
        setup(2, 3);
        wr(RA_CTRL, 1);
        base = ecnt;
        for (int i = 0; i <= 20; i++) begin
            e = ecnt - base;
            chk("R6 single pulse", {31'd0, irq_o}, (e == 9) ? 1 : 0);
            rd(RA_COUNT, v); chk("R6 count", v, e / 4);
            step();
        end

        // R7 auto-restart at the compare value
        setup(4, 0);
        wr(RA_CTRL, 3);
        base = ecnt;
        for (int i = 0; i <= 16; i++) begin
            e = ecnt - base;
            rd(RA_COUNT, v); chk("R7 restart count", v, e % 5);
            chk("R7 periodic event", {31'd0, irq_o}, (e > 0 && e % 5 == 0) ? 1 : 0);
            step();
        end

        // R11 stopped at the compare value raises nothing
        wr(RA_CTRL, 0);
        rd(RA_COUNT, c0);
        wr(RA_MATCH, c0);
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R11 no event when stopped", {31'd0, irq_o}, 0);
            rd(RA_COUNT, v); chk("R11 count held", v, c0);
        end

        // R8 wrap and R9 compare value behind the count
        setup(32'hC8, 0);
        wr(RA_CTRL, 1);
        base = ecnt;
        while (ecnt - base < 10) step();
        wr(RA_MATCH, 3);
        while (ecnt - base <= 262) begin
            e = ecnt - base;
            rd(RA_COUNT, v);
            if (e == 255 || e == 256) chk("R8 wrap", v, e % 256);
            else                      chk("R9 count", v, e % 256);
            chk("R9 event only after wrap", {31'd0, irq_o}, (e == 260) ? 1 : 0);
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule